// File: doc/BRIEF.md
# Serial-Frame 1-Wire Bus Master

This block is a 1-Wire bus master that forms every bus time slot out of one asynchronous serial frame: a start bit, eight data bits sent least-significant first, and a stop bit. The chosen data pattern sets how long the line stays low. A write-one or read slot sends all ones, so only the start bit pulls the line down. A write-zero slot sends all zeros, so the line stays low for nine bit periods. A reset slot sends a mixed pattern at a much slower bit rate. The block drives the line open-drain. A receiver watches the line, samples the echoed frame at mid-bit, and uses the echo to decode read bits, device presence and a shorted bus.

A host issues one command at a time with a valid strobe while the block reports ready. The commands are reset, write bit, read bit, write byte, read byte and speed select. Each command ends with a single-cycle done strobe. The read data and the presence, short and error flags are held from that strobe until the next one. Bit periods are counted in clock cycles from four divisor parameters: data and reset, each at normal and overdrive speed. A per-slot timeout protects against a line that never shows the frame's falling edge.

Top module: `ow_uart_master`

## Requirements
- R1: After reset the block is ready, the line is released (line_oe low), done, err, presence and bus_short are low, and normal speed is selected.
- R2: A write-bit command (op 1, value in cmd_data[0]) sends one frame. The line is driven low for exactly one data bit period when the value is 1, and for nine consecutive bit periods when it is 0.
- R3: A read-bit command (op 2) sends an all-ones frame. rd_data[0] is 1 only if every echoed data bit is 1, and 0 when any echoed data bit is 0. The upper bits of rd_data are zero.
- R4: A reset command (op 0) uses the reset bit period for the current speed. At normal speed it sends pattern 0xF0, giving a low time of five reset bit periods. At overdrive it sends 0xE0, giving a low time of six reset bit periods.
- R5: After a reset, presence is 1 when the echoed byte differs from the pattern sent and is not zero. It is 0 when the echo equals the pattern.
- R6: An all-zero reset echo sets bus_short to 1 and keeps presence at 0. presence and bus_short are never high together.
- R7: Byte commands (write op 3, read op 4) run eight slots, least-significant bit first. A read byte assembles the decoded bits LSB first into rd_data.
- R8: A speed command (op 5) selects overdrive when cmd_data[0] is 1 and normal speed when it is 0. It completes with done one cycle after acceptance. Later slots use the overdrive data and reset bit periods.
- R9: A speed command that requests the speed already in use leaves the slot timing unchanged.
- R10: If no falling edge appears on line_in within TMO_BIT cycles of a data slot's start, or 12 times that for a reset slot, the command ends with done and err high and the line released. A later successful command clears err.
- R11: line_oe is high only while the frame bit being sent is 0, and it is low whenever the block is ready.
- R12: done is a one-cycle strobe given only as the block returns to ready. rd_data, presence, bus_short and err change only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready is high |
| cmd_op | input | 3 | 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte, 5 speed |
| cmd_data | input | 8 | Write value, or speed select in bit 0 |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Decoded read bit or byte |
| presence | output | 1 | Device answered the last reset |
| bus_short | output | 1 | Last reset echo was all zeros |
| err | output | 1 | Last command ended by echo timeout |
| line_oe | output | 1 | Pull the open-drain bus low |
| line_in | input | 1 | Level seen on the bus |

## Verification
A speed command raises done on the first cycle after it is accepted. A slot command raises done a few cycles after the last frame's stop bit, which is ten bit periods per slot. A timed-out command raises done three to four cycles after its timeout count runs out. The bench drives at falling clock edges and polls done at each falling edge, with a bound. It measures every low run of line_oe in clock cycles, so slot widths are compared exactly against the divisor parameters. Timeout latency is compared against a window of a few cycles above the timeout count.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4,
    OP_SPEED = 3'd5
  } ow_op_e;

  localparam logic [7:0] PAT_RST_NORM = 8'hF0;
  localparam logic [7:0] PAT_RST_FAST = 8'hE0;
  localparam logic [7:0] PAT_ONES     = 8'hFF;
  localparam logic [7:0] PAT_ZEROS    = 8'h00;
  localparam int         RST_TMO_MULT = 12;
endpackage

// File: rtl/ow_frame_tx.sv
module ow_frame_tx #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [7:0]    pattern,
  input  logic [CW-1:0] div,
  output logic          oe,
  output logic          busy
);
  logic [9:0]    sh;
  logic [3:0]    left;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      oe   <= 1'b0;
      busy <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
      oe   <= 1'b0;
    end else if (start) begin
      sh   <= {1'b1, pattern, 1'b0};
      left <= 4'd9;
      cnt  <= div - 1'b1;
      busy <= 1'b1;
      oe   <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) begin
        if (left == '0) begin
          busy <= 1'b0;
          oe   <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[9:1]};
          oe   <= ~sh[1];
          left <= left - 1'b1;
          cnt  <= div - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ow_echo_rx.sv
module ow_echo_rx #(
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          line_in,
  input  logic [CW-1:0] div,
  input  logic [TW-1:0] tmo,
  output logic          done,
  output logic          timeout,
  output logic [7:0]    data
);
  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_BITS} rx_st_e;
  rx_st_e      st;
  logic        s1, s2, s3;
  logic [CW:0] cnt;
  logic [TW-1:0] tcnt;
  logic [2:0]  nb;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE;
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      cnt <= '0; tcnt <= '0; nb <= '0;
      done <= 1'b0; timeout <= 1'b0; data <= '0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      s3 <= s2;
      done    <= 1'b0;
      timeout <= 1'b0;
      if (arm) begin
        data <= '0;
        tcnt <= tmo;
        st   <= RX_WAIT;
      end else begin
        case (st)
          RX_WAIT: begin
            if (s3 && !s2) begin
              cnt <= {1'b0, div} + {2'b0, div[CW-1:1]} - 1'b1;
              nb  <= '0;
              st  <= RX_BITS;
            end else if (tcnt == '0) begin
              timeout <= 1'b1;
              st      <= RX_IDLE;
            end else begin
              tcnt <= tcnt - 1'b1;
            end
          end
          RX_BITS: begin
            if (cnt == '0) begin
              data <= {s2, data[7:1]};
              if (nb == 3'd7) begin
                done <= 1'b1;
                st   <= RX_IDLE;
              end else begin
                nb  <= nb + 1'b1;
                cnt <= {1'b0, div} - 1'b1;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_uart_master.sv
module ow_uart_master
  import ow_pkg::*;
#(
  parameter int DIV_NORM_DATA = 2170,
  parameter int DIV_NORM_RST  = 26042,
  parameter int DIV_FAST_DATA = 250,
  parameter int DIV_FAST_RST  = 2170,
  parameter int TMO_BIT       = 4340
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       cmd_ready,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       presence,
  output logic       bus_short,
  output logic       err,
  output logic       line_oe,
  input  logic       line_in
);
  localparam int MAX_D  = (DIV_NORM_DATA > DIV_NORM_RST) ? DIV_NORM_DATA : DIV_NORM_RST;
  localparam int MAX_F  = (DIV_FAST_DATA > DIV_FAST_RST) ? DIV_FAST_DATA : DIV_FAST_RST;
  localparam int MAXDIV = (MAX_D > MAX_F) ? MAX_D : MAX_F;
  localparam int CW     = $clog2(MAXDIV + 1);
  localparam int TW     = $clog2(TMO_BIT * RST_TMO_MULT + 1);
  localparam logic [CW-1:0] DV_ND = CW'(DIV_NORM_DATA);
  localparam logic [CW-1:0] DV_NR = CW'(DIV_NORM_RST);
  localparam logic [CW-1:0] DV_FD = CW'(DIV_FAST_DATA);
  localparam logic [CW-1:0] DV_FR = CW'(DIV_FAST_RST);
  localparam logic [TW-1:0] TM_D  = TW'(TMO_BIT);
  localparam logic [TW-1:0] TM_R  = TW'(TMO_BIT * RST_TMO_MULT);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e        state;
  ow_op_e     op_q;
  logic       od, launch, got;
  logic [7:0] shreg, acc, echo_q;
  logic [3:0] slots;

  logic          tx_busy, rx_done, rx_tmo;
  logic [7:0]    rx_data, frame_pat, acc_n;
  logic [CW-1:0] cur_div;
  logic [TW-1:0] cur_tmo;
  logic          is_rst, bitv, frame_end;

  always_comb begin
    is_rst    = (op_q == OP_RESET);
    frame_pat = is_rst ? (od ? PAT_RST_FAST : PAT_RST_NORM)
                       : (shreg[0] ? PAT_ONES : PAT_ZEROS);
    cur_div   = is_rst ? (od ? DV_FR : DV_NR) : (od ? DV_FD : DV_ND);
    cur_tmo   = is_rst ? TM_R : TM_D;
    bitv      = (echo_q == PAT_ONES);
    acc_n     = {bitv, acc[7:1]};
    frame_end = !launch && !tx_busy && got;
  end

  assign cmd_ready = (state == ST_IDLE);

  ow_frame_tx #(.CW(CW)) u_tx (
    .clk(clk), .rst(rst), .start(launch), .abort(rx_tmo),
    .pattern(frame_pat), .div(cur_div), .oe(line_oe), .busy(tx_busy)
  );

  ow_echo_rx #(.CW(CW), .TW(TW)) u_rx (
    .clk(clk), .rst(rst), .arm(launch), .line_in(line_in),
    .div(cur_div), .tmo(cur_tmo), .done(rx_done), .timeout(rx_tmo),
    .data(rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; op_q <= OP_SPEED; od <= 1'b0;
      launch <= 1'b0; got <= 1'b0;
      shreg <= '0; acc <= '0; echo_q <= '0; slots <= '0;
      done <= 1'b0; rd_data <= '0; presence <= 1'b0;
      bus_short <= 1'b0; err <= 1'b0;
    end else begin
      done   <= 1'b0;
      launch <= 1'b0;
      if (rx_done) begin
        got    <= 1'b1;
        echo_q <= rx_data;
      end
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q <= ow_op_e'(cmd_op);
          acc  <= '0;
          got  <= 1'b0;
          case (ow_op_e'(cmd_op))
            OP_RESET: begin shreg <= PAT_ONES; slots <= 4'd1; launch <= 1'b1; state <= ST_RUN; end
            OP_WBIT:  begin shreg <= {7'b0, cmd_data[0]}; slots <= 4'd1; launch <= 1'b1; state <= ST_RUN; end
            OP_RBIT:  begin shreg <= PAT_ONES; slots <= 4'd1; launch <= 1'b1; state <= ST_RUN; end
            OP_WBYTE: begin shreg <= cmd_data; slots <= 4'd8; launch <= 1'b1; state <= ST_RUN; end
            OP_RBYTE: begin shreg <= PAT_ONES; slots <= 4'd8; launch <= 1'b1; state <= ST_RUN; end
            default: begin
              if (ow_op_e'(cmd_op) == OP_SPEED) od <= cmd_data[0];
              done <= 1'b1; err <= 1'b0; presence <= 1'b0; bus_short <= 1'b0;
            end
          endcase
        end
        ST_RUN: begin
          if (rx_tmo) begin
            done <= 1'b1; err <= 1'b1; rd_data <= '0;
            presence <= 1'b0; bus_short <= 1'b0;
            state <= ST_IDLE;
          end else if (frame_end) begin
            got <= 1'b0;
            if (is_rst) begin
              presence  <= (echo_q != frame_pat) && (echo_q != PAT_ZEROS);
              bus_short <= (echo_q == PAT_ZEROS);
              rd_data   <= '0;
              err <= 1'b0; done <= 1'b1; state <= ST_IDLE;
            end else if (slots == 4'd1) begin
              rd_data   <= (op_q == OP_WBYTE || op_q == OP_RBYTE) ? acc_n : {7'b0, bitv};
              presence  <= 1'b0; bus_short <= 1'b0;
              err <= 1'b0; done <= 1'b1; state <= ST_IDLE;
            end else begin
              acc    <= acc_n;
              slots  <= slots - 1'b1;
              shreg  <= {1'b0, shreg[7:1]};
              launch <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_uart_master_chk.sv
module ow_uart_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_ready,
  input logic       done,
  input logic       line_oe,
  input logic       presence,
  input logic       bus_short,
  input logic       err,
  input logic [7:0] rd_data
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !line_oe); // R11
  AST_PRES_NOT_SHORT: assert property (@(posedge clk) disable iff (rst)
    !(presence && bus_short)); // R6
  AST_DONE_AT_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready); // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rd_data) && $stable(presence) && $stable(bus_short) && $stable(err))); // R12
endmodule

bind ow_uart_master ow_uart_master_chk u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .done(done),
  .line_oe(line_oe), .presence(presence), .bus_short(bus_short),
  .err(err), .rd_data(rd_data)
);

// File: tb/ow_uart_master_bench.sv
`timescale 1ns/1ps
module ow_uart_master_bench;
  localparam int D_ND = 20;
  localparam int D_NR = 240;
  localparam int D_FD = 6;
  localparam int D_FR = 52;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_ready, done, presence, bus_short, err, line_oe;
  logic [7:0] rd_data;
  logic pull = 1'b0;
  logic stuck_high = 1'b0;
  logic line_in;

  assign line_in = stuck_high ? 1'b1 : !(line_oe || pull);
  always #2 clk = ~clk;

  ow_uart_master #(
    .DIV_NORM_DATA(D_ND), .DIV_NORM_RST(D_NR),
    .DIV_FAST_DATA(D_FD), .DIV_FAST_RST(D_FR), .TMO_BIT(TMO)
  ) u_ow_uart_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .done(done),
    .rd_data(rd_data), .presence(presence), .bus_short(bus_short),
    .err(err), .line_oe(line_oe), .line_in(line_in)
  );

  int errs = 0, checks = 0;
  int runs[16];
  int nruns = 0, run = 0, lat = 0;
  int smode = 0, sdiv = D_ND, pstart = 6, idx = 0;
  logic [7:0] rbyte = '0;

  always @(posedge clk) begin
    if (line_oe) run++;
    else if (run > 0) begin
      if (nruns < 16) runs[nruns] = run;
      nruns++;
      run = 0;
    end
  end

  initial begin
    forever begin
      @(posedge line_oe);
      if (smode == 1) begin
        if (!rbyte[idx % 8]) begin
          pull = 1'b1; repeat (3 * sdiv) @(posedge clk); pull = 1'b0;
        end
        idx++;
      end else if (smode == 2) begin
        repeat (pstart * sdiv) @(posedge clk);
        pull = 1'b1; repeat (2 * sdiv) @(posedge clk); pull = 1'b0;
      end else if (smode == 3) begin
        pull = 1'b1; repeat (11 * sdiv) @(posedge clk); pull = 1'b0;
      end
    end
  end

  function automatic int slot_low(input bit b, input int d);
    return b ? d : 9 * d;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] d);
    while (!cmd_ready) @(negedge clk);
    while (pull) @(negedge clk);
    nruns = 0; run = 0; idx = 0;
    cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 30000) begin @(negedge clk); lat++; end
    if (!done) chk(1'b0, "R12 done missing", 0, 1);
  endtask

  task automatic wbit_width(input bit b, input int d, input string tag);
    smode = 0;
    cmd(3'd1, {7'b0, b});
    chk(nruns == 1 && runs[0] == slot_low(b, d), tag, runs[0], slot_low(b, d));
  endtask

  task automatic do_reset(input int mode, input int ps, input int d);
    smode = mode; pstart = ps; sdiv = d;
    cmd(3'd0, 8'h00);
    smode = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !line_oe && !done && !err && !presence && !bus_short,
        "R1 reset state", {cmd_ready, line_oe, done, err, presence, bus_short}, 6'b100000);

    wbit_width(1'b1, D_ND, "R2 write one normal");
    wbit_width(1'b0, D_ND, "R2 write zero normal");
    chk(!line_oe, "R11 released after slot", line_oe, 0);

    smode = 1; sdiv = D_ND; rbyte = 8'hFF; cmd(3'd2, 8'h00);
    chk(rd_data == 8'h01, "R3 read bit one", rd_data, 1);
    smode = 1; rbyte = 8'h00; cmd(3'd2, 8'h00);
    chk(rd_data == 8'h00, "R3 read bit zero", rd_data, 0);

    do_reset(0, 6, D_NR);
    chk(nruns == 1 && runs[0] == 5 * D_NR, "R4 reset low normal", runs[0], 5 * D_NR);
    chk(!presence && !bus_short, "R5 no device", presence, 0);
    do_reset(2, 6, D_NR);
    chk(presence && !bus_short, "R5 presence normal", presence, 1);
    do_reset(3, 6, D_NR);
    chk(bus_short && !presence, "R6 short flagged", {bus_short, presence}, 2);

    smode = 0; cmd(3'd3, 8'hA5);
    for (int i = 0; i < 8; i++)
      chk(runs[i] == slot_low(8'hA5 >> i & 1, D_ND), "R7 write byte LSB first", runs[i], slot_low(8'hA5 >> i & 1, D_ND));
    smode = 1; sdiv = D_ND; rbyte = 8'h3C; cmd(3'd4, 8'h00);
    chk(rd_data == 8'h3C, "R7 read byte", rd_data, 8'h3C);

    cmd(3'd5, 8'h00);
    chk(lat == 1, "R8 speed done latency", lat, 1);
    wbit_width(1'b1, D_ND, "R9 same speed normal");

    cmd(3'd5, 8'h01);
    wbit_width(1'b1, D_FD, "R8 write one fast");
    wbit_width(1'b0, D_FD, "R8 write zero fast");
    cmd(3'd5, 8'h01);
    wbit_width(1'b1, D_FD, "R9 same speed fast");
    do_reset(0, 7, D_FR);
    chk(nruns == 1 && runs[0] == 6 * D_FR, "R4 reset low fast", runs[0], 6 * D_FR);
    chk(!presence, "R5 no device fast", presence, 0);
    do_reset(2, 7, D_FR);
    chk(presence && !bus_short, "R5 presence fast", presence, 1);

    for (int k = 0; k < 12; k++) begin
      bit fast, rd;
      logic [7:0] b;
      int d;
      fast = 1'($urandom % 2);
      rd   = 1'($urandom % 2);
      b    = 8'($urandom % 256);
      d    = fast ? D_FD : D_ND;
      cmd(3'd5, {7'b0, fast});
      if (rd) begin
        smode = 1; sdiv = d; rbyte = b; cmd(3'd4, 8'h00); smode = 0;
        chk(rd_data == b, "R7 random read byte", rd_data, b);
      end else begin
        smode = 0; cmd(3'd3, b);
        for (int i = 0; i < 8; i++)
          chk(runs[i] == slot_low(b >> i & 1, d), "R7 random write byte", runs[i], slot_low(b >> i & 1, d));
      end
    end

    cmd(3'd5, 8'h00);
    stuck_high = 1'b1;
    cmd(3'd1, 8'h01);
    chk(err && lat >= TMO && lat <= TMO + 8, "R10 data timeout", lat, TMO);
    chk(!line_oe, "R10 line released on timeout", line_oe, 0);
    cmd(3'd0, 8'h00);
    chk(err && lat >= 12 * TMO && lat <= 12 * TMO + 8, "R10 reset timeout", lat, 12 * TMO);
    stuck_high = 1'b0;
    repeat (4) @(negedge clk);
    wbit_width(1'b1, D_ND, "R10 recovery width");
    chk(!err, "R10 err cleared", err, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule